// File: doc/BRIEF.md
# Serial EEPROM Command Sequencer

This block is the serial front end of a byte-addressed nonvolatile memory model. It receives SPI traffic in clock mode 0 or mode 3 on the serial clock, data-in and active-low chip-select pins. Those pins and the active-low hold pin are synchronised into a faster system clock, and their edges are detected there. The block decodes an 8-bit instruction, collects a 16-bit address and data bytes, and issues requests to a behavioural storage array and to a status/protection unit. Both of these lie outside the block.

Reads stream out bytes from ascending addresses. The address runs through the whole 4096-byte space and wraps to zero. Write data is handed over byte by byte as page-load strobes, and a commit strobe follows when chip select rises cleanly on a byte boundary. A commit starts a self-timed internal write, during which a busy flag is set. While busy is set, the block serves only the status-read instruction.

The protection unit decides whether a commit actually changes anything. The sequencer only reports what the serial stream asked for.

Top module: `spi_eeprom_seq`

## Requirements
- R1: After reset, so_oe and busy are 0 and no strobe (pg_we, wr_commit, sr_commit, wen_set, wen_clr) is pulsed.
- R2: The instruction is the first 8 bits after chip select falls, sent MSB first. Its upper nibble must be 0 and bit 3 is ignored. Low bits 110 pulse wen_set and low bits 100 pulse wen_clr, each once, when chip select rises on a byte boundary.
- R3: Instruction 0000x011 is followed by a 16-bit address, of which bits 15..12 are ignored. Data then leaves on so MSB first. Each bit changes after a falling serial-clock edge and is valid at the next rising edge. The first bit follows the fall after the last address bit.
- R4: A read keeps returning bytes from ascending addresses while clocks continue, and wraps from 0x0FFF to 0x0000.
- R5: Instruction 0000x101 returns the byte {stat_hi, busy} on every following byte until chip select rises.
- R6: Instruction 0000x010 plus an address yields one pg_we pulse per complete data byte, carrying that byte and its address. The address then increments within its 32-byte page and wraps to the page start.
- R7: wr_commit pulses only if chip select rises on a byte boundary after at least one data byte. A rise in mid-byte, or with no data byte, gives no commit and no busy period.
- R8: Instruction 0000x001 with one data byte pulses sr_commit with sr_data equal to that byte when chip select rises on a byte boundary.
- R9: A commit sets busy for exactly WR_CYCLES system clocks. While busy is set, every instruction other than status read produces no strobe and no output enable.
- R10: While hold_n is low, the serial clock and data-in are ignored and so_oe is 0. After release, the transfer resumes at the bit where it stopped.
- R11: so_oe is 1 only in a read or status-read data phase with chip select low, and it is 0 once chip select is high.
- R12: An opcode with a nonzero upper nibble or with low bits 000 or 111 is ignored until chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low transfer suspend |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so (0 = high impedance) |
| stat_hi | input | 7 | Status bits 7..1 from the protection unit |
| mem_addr | output | ADDR_W | Read address to the storage array |
| mem_rdata | input | 8 | Byte at mem_addr, combinational |
| pg_we | output | 1 | One-cycle page-load strobe |
| pg_addr | output | ADDR_W | Address for pg_data |
| pg_data | output | 8 | Data byte to load |
| wr_commit | output | 1 | Start array write of loaded bytes |
| sr_commit | output | 1 | Start status-register write |
| sr_data | output | 8 | Status byte to write |
| wen_set | output | 1 | Set write-enable latch |
| wen_clr | output | 1 | Clear write-enable latch |
| busy | output | 1 | Internal write cycle running |

## Verification
The assertions take for granted that the serial clock is slow against the system clock: each level lasts several system cycles, so that no edge is lost in the synchroniser. They also assume that chip select and hold change only while the serial clock is low, or is idle high in mode 3. The bench keeps the serial half period at eight system clocks and moves hold only with the clock low. It drives every pin a few nanoseconds after a system edge, so that the synchronised view is unambiguous.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;
  // Sequencer phases
  typedef enum logic [3:0] {
    SQ_IDLE, SQ_OPC, SQ_ADDR, SQ_RD, SQ_WR, SQ_STAT, SQ_SRIN, SQ_LATCH, SQ_SKIP
  } seq_st_t;

  // Low three opcode bits (upper nibble must be zero, bit 3 ignored)
  localparam logic [2:0] OPL_WEN_SET = 3'b110;
  localparam logic [2:0] OPL_WEN_CLR = 3'b100;
  localparam logic [2:0] OPL_STAT_RD = 3'b101;
  localparam logic [2:0] OPL_STAT_WR = 3'b001;
  localparam logic [2:0] OPL_READ    = 3'b011;
  localparam logic [2:0] OPL_WRITE   = 3'b010;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RV = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RV;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/wr_timer.sv
module wr_timer #(
  parameter int CYC = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYC);

  logic [CW-1:0] cnt, cnt_n;

  always_comb begin
    cnt_n = cnt;
    if (start)         cnt_n = LOAD;
    else if (cnt != '0) cnt_n = cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end

  assign busy = (cnt != '0);

  // R9: a busy period only ever opens right after a start request
  a_r9_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import eeprom_seq_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              si_s,
  input  logic              csn_s,
  input  logic              hold_s,
  input  logic              busy,
  input  logic [6:0]        stat_hi,
  input  logic [7:0]        mem_rdata,
  output logic              so,
  output logic              so_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              pg_we,
  output logic [ADDR_W-1:0] pg_addr,
  output logic [7:0]        pg_data,
  output logic              wr_commit,
  output logic              sr_commit,
  output logic [7:0]        sr_data,
  output logic              wen_set,
  output logic              wen_clr
);
  localparam int HI_W = ADDR_W - 8;

  seq_st_t           st, st_n;
  logic [2:0]        bitcnt, bitcnt_n, obit, obit_n, op, op_n;
  logic [7:0]        shin, shin_n;
  logic [6:0]        osh, osh_n;
  logic [ADDR_W-1:0] addr, addr_n, pga, pga_n;
  logic [7:0]        pgd, pgd_n, srd, srd_n;
  logic              aidx, aidx_n, hasd, hasd_n, so_r, so_n;
  logic              sck_q, csn_q;
  logic              pgw_n, wrc_n, src_n, wset_n, wclr_n;
  logic              pgw_r, wrc_r, src_r, wset_r, wclr_r;
  logic              act, rise, fall, cs_up, cs_dn, bdone;
  logic [7:0]        nbyte, obyte;

  always_comb begin
    act   = ~csn_s & hold_s;
    rise  = act & sck_s & ~sck_q;
    fall  = act & ~sck_s & sck_q;
    cs_up = csn_s & ~csn_q;
    cs_dn = ~csn_s & csn_q;
    nbyte = {shin[6:0], si_s};
    bdone = rise & (bitcnt == 3'd7);
    obyte = (st == SQ_STAT) ? {stat_hi, busy} : mem_rdata;

    st_n = st; bitcnt_n = bitcnt; obit_n = obit; op_n = op; shin_n = shin;
    osh_n = osh; addr_n = addr; pga_n = pga; pgd_n = pgd; srd_n = srd;
    aidx_n = aidx; hasd_n = hasd; so_n = so_r;
    pgw_n = 1'b0; wrc_n = 1'b0; src_n = 1'b0; wset_n = 1'b0; wclr_n = 1'b0;

    if (cs_up) begin
      st_n = SQ_IDLE;
      if (bitcnt == 3'd0) begin
        if (st == SQ_WR   && hasd) wrc_n = 1'b1;
        if (st == SQ_SRIN && hasd) src_n = 1'b1;
        if (st == SQ_LATCH) begin
          wset_n = (op == OPL_WEN_SET);
          wclr_n = (op == OPL_WEN_CLR);
        end
      end
    end else if (cs_dn) begin
      st_n = SQ_OPC; bitcnt_n = '0; obit_n = '0; aidx_n = 1'b0; hasd_n = 1'b0;
    end else begin
      if (rise) begin
        shin_n   = nbyte;
        bitcnt_n = bitcnt + 3'd1;
      end
      if (bdone) begin
        unique case (st)
          SQ_OPC: begin
            op_n = nbyte[2:0];
            st_n = SQ_SKIP;
            if (nbyte[7:4] == 4'd0) begin
              if (nbyte[2:0] == OPL_STAT_RD) st_n = SQ_STAT;
              else if (!busy) begin
                unique case (nbyte[2:0])
                  OPL_WEN_SET, OPL_WEN_CLR: st_n = SQ_LATCH;
                  OPL_STAT_WR:              st_n = SQ_SRIN;
                  OPL_READ, OPL_WRITE:      st_n = SQ_ADDR;
                  default:                  st_n = SQ_SKIP;
                endcase
              end
            end
          end
          SQ_ADDR: begin
            aidx_n = 1'b1;
            if (!aidx) addr_n[ADDR_W-1:8] = nbyte[HI_W-1:0];
            else begin
              addr_n[7:0] = nbyte;
              st_n = (op == OPL_READ) ? SQ_RD : SQ_WR;
            end
          end
          SQ_WR: begin
            pgw_n  = 1'b1;
            pga_n  = addr;
            pgd_n  = nbyte;
            hasd_n = 1'b1;
            addr_n = {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + 1'b1};
          end
          SQ_SRIN: begin
            srd_n  = nbyte;
            hasd_n = 1'b1;
          end
          default: ;
        endcase
      end
      if (fall && (st == SQ_RD || st == SQ_STAT)) begin
        obit_n = obit + 3'd1;
        if (obit == 3'd0) begin
          so_n  = obyte[7];
          osh_n = obyte[6:0];
          if (st == SQ_RD) addr_n = addr + 1'b1;
        end else begin
          so_n  = osh[6];
          osh_n = {osh[5:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= SQ_IDLE; bitcnt <= '0; obit <= '0; op <= '0; shin <= '0; osh <= '0;
      addr <= '0; pga <= '0; pgd <= '0; srd <= '0; aidx <= 1'b0; hasd <= 1'b0;
      so_r <= 1'b0; sck_q <= 1'b0; csn_q <= 1'b1;
      pgw_r <= 1'b0; wrc_r <= 1'b0; src_r <= 1'b0; wset_r <= 1'b0; wclr_r <= 1'b0;
    end else begin
      st <= st_n; bitcnt <= bitcnt_n; obit <= obit_n; op <= op_n; shin <= shin_n;
      osh <= osh_n; addr <= addr_n; pga <= pga_n; pgd <= pgd_n; srd <= srd_n;
      aidx <= aidx_n; hasd <= hasd_n; so_r <= so_n; sck_q <= sck_s; csn_q <= csn_s;
      pgw_r <= pgw_n; wrc_r <= wrc_n; src_r <= src_n; wset_r <= wset_n; wclr_r <= wclr_n;
    end
  end

  assign so        = so_r;
  assign so_oe     = (st == SQ_RD || st == SQ_STAT) & ~csn_s & hold_s;
  assign mem_addr  = addr;
  assign pg_we     = pgw_r;
  assign pg_addr   = pga;
  assign pg_data   = pgd;
  assign wr_commit = wrc_r;
  assign sr_commit = src_r;
  assign sr_data   = srd;
  assign wen_set   = wset_r;
  assign wen_clr   = wclr_r;

  // R2: at most one end-of-transfer request per cycle
  a_r2_single_request: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wrc_r, src_r, wset_r, wclr_r}));
  // R9: array streaming never runs during an internal write
  a_r9_no_stream_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_RD) |-> !busy);
endmodule

// File: rtl/spi_eeprom_seq.sv
module spi_eeprom_seq #(
  parameter int ADDR_W    = 12,
  parameter int PAGE_W    = 5,
  parameter int SYNC_STG  = 2,
  parameter int WR_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              si,
  input  logic              hold_n,
  output logic              so,
  output logic              so_oe,
  input  logic [6:0]        stat_hi,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              pg_we,
  output logic [ADDR_W-1:0] pg_addr,
  output logic [7:0]        pg_data,
  output logic              wr_commit,
  output logic              sr_commit,
  output logic [7:0]        sr_data,
  output logic              wen_set,
  output logic              wen_clr,
  output logic              busy
);
  logic [1:0] rst_pipe;
  logic       rst_sn;
  logic [3:0] pins_s;

  // Reset asserts at once, releases after two clean clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  spi_pin_sync #(.W(4), .STAGES(SYNC_STG), .RV(4'b1100)) u_sync (
    .clk(clk), .rst_n(rst_sn), .d({hold_n, cs_n, si, sck}), .q(pins_s)
  );

  spi_cmd_seq #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_seq (
    .clk(clk), .rst_n(rst_sn),
    .sck_s(pins_s[0]), .si_s(pins_s[1]), .csn_s(pins_s[2]), .hold_s(pins_s[3]),
    .busy(busy), .stat_hi(stat_hi), .mem_rdata(mem_rdata),
    .so(so), .so_oe(so_oe), .mem_addr(mem_addr),
    .pg_we(pg_we), .pg_addr(pg_addr), .pg_data(pg_data),
    .wr_commit(wr_commit), .sr_commit(sr_commit), .sr_data(sr_data),
    .wen_set(wen_set), .wen_clr(wen_clr)
  );

  wr_timer #(.CYC(WR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_sn), .start(wr_commit | sr_commit), .busy(busy)
  );

  // R9: every commit opens a busy period on the next cycle
  a_r9_busy_follows_commit: assert property (@(posedge clk) disable iff (!rst_sn)
    (wr_commit || sr_commit) |=> busy);
  // R9: no page data is handed over while a write cycle runs
  a_r9_no_load_while_busy: assert property (@(posedge clk) disable iff (!rst_sn)
    pg_we |-> !busy);
endmodule

// File: tb/spi_eeprom_seq_test.sv
`timescale 1ns/1ps
module spi_eeprom_seq_test;
  localparam int WRC  = 2000;
  localparam int HALF = 80;

  logic clk = 1'b0;
  logic rst_n, sck, cs_n, si, hold_n;
  logic so, so_oe, pg_we, wr_commit, sr_commit, wen_set, wen_clr, busy;
  logic [11:0] mem_addr, pg_addr;
  logic [7:0]  mem_rdata, pg_data, sr_data;
  logic [6:0]  stat_hi = 7'h52; // status byte 0xA4 when idle, 0xA5 when busy

  always #5 clk = ~clk;

  spi_eeprom_seq #(.WR_CYCLES(WRC)) uut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
    .so(so), .so_oe(so_oe), .stat_hi(stat_hi), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .pg_we(pg_we), .pg_addr(pg_addr), .pg_data(pg_data),
    .wr_commit(wr_commit), .sr_commit(sr_commit), .sr_data(sr_data),
    .wen_set(wen_set), .wen_clr(wen_clr), .busy(busy)
  );

  function automatic logic [7:0] pat(input logic [11:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
  endfunction

  // Storage array model with page latch
  logic [7:0] mem [4096];
  logic [7:0] pend [4096];
  logic       pv [4096];
  logic       cs_prev;
  int n_pg, n_wc, n_sc, n_ws, n_wclr, busy_len;

  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    cs_prev <= cs_n;
    if (!rst_n) begin
      for (int i = 0; i < 4096; i++) begin mem[i] <= pat(12'(i)); pv[i] <= 1'b0; end
      n_pg <= 0; n_wc <= 0; n_sc <= 0; n_ws <= 0; n_wclr <= 0; busy_len <= 0;
    end else begin
      if (cs_prev && !cs_n) for (int i = 0; i < 4096; i++) pv[i] <= 1'b0;
      if (pg_we) begin pend[pg_addr] <= pg_data; pv[pg_addr] <= 1'b1; n_pg <= n_pg + 1; end
      if (wr_commit) begin
        n_wc <= n_wc + 1;
        for (int i = 0; i < 4096; i++) if (pv[i]) begin mem[i] <= pend[i]; pv[i] <= 1'b0; end
      end
      if (sr_commit) n_sc <= n_sc + 1;
      if (wen_set) n_ws <= n_ws + 1;
      if (wen_clr) n_wclr <= n_wclr + 1;
      if (wr_commit || sr_commit) busy_len <= 0;
      else if (busy) busy_len <= busy_len + 1;
    end
  end

  int n_chk = 0, n_bad = 0;
  logic [7:0] tx [16];
  logic [7:0] rx [16];
  logic oe_seen, hold_oe;
  int hold_bit;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xact(input int nbits, input bit m3);
    oe_seen = 1'b0;
    sck = m3; cs_n = 1'b0; #(HALF);
    for (int i = 0; i < nbits; i++) begin
      sck = 1'b0; si = tx[i/8][7 - i%8]; #(HALF);
      if (i == hold_bit) begin
        hold_n = 1'b0; #(HALF);
        hold_oe = so_oe;
        sck = 1'b1; #(HALF); sck = 1'b0; #(HALF);
        sck = 1'b1; #(HALF); sck = 1'b0; #(HALF);
        hold_n = 1'b1; #(HALF);
      end
      rx[i/8][7 - i%8] = so;
      oe_seen = oe_seen | so_oe;
      sck = 1'b1; #(HALF);
    end
    if (!m3) begin sck = 1'b0; #(HALF); end
    cs_n = 1'b1; #(2*HALF);
  endtask

  task automatic wait_idle();
    for (int t = 0; t < 20000 && busy; t++) @(posedge clk);
    #3;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  // Read vectors: [31:24] mode, [23:8] address as sent, [7:0] byte count
  localparam logic [31:0] RVEC [6] = '{
    {8'd0, 16'h0000, 8'd2}, {8'd1, 16'h0123, 8'd3}, {8'd0, 16'hF010, 8'd2},
    {8'd1, 16'h0FFE, 8'd4}, {8'd0, 16'h7ABC, 8'd2}, {8'd1, 16'h0800, 8'd1}
  };

  initial begin
    #1500000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    int b0, b1;
    rst_n = 1'b0; sck = 1'b0; cs_n = 1'b1; si = 1'b0; hold_n = 1'b1; hold_bit = -1;
    hold_oe = 1'b1;
    #53 rst_n = 1'b1; #50;
    // R1 reset state
    chk("R1 so_oe", so_oe, 0);
    chk("R1 busy", busy, 0);
    chk("R1 strobes", n_pg + n_wc + n_sc + n_ws + n_wclr, 0);

    // R3/R4 read vectors
    foreach (RVEC[v]) begin
      logic [15:0] a16 = RVEC[v][23:8];
      int nb = int'(RVEC[v][7:0]);
      tx[0] = 8'h03; tx[1] = a16[15:8]; tx[2] = a16[7:0];
      xact(24 + 8*nb, RVEC[v][24]);
      for (int k = 0; k < nb; k++)
        chk("R3 R4 read byte", rx[3+k], pat(a16[11:0] + 12'(k)));
      chk("R11 oe during read", oe_seen, 1);
      chk("R11 oe after cs", so_oe, 0);
    end

    // R5 status read repeats
    tx[0] = 8'h05; xact(24, 0);
    chk("R5 status byte 1", rx[1], 8'hA4);
    chk("R5 status byte 2", rx[2], 8'hA4);

    // R2 write-enable latch opcodes, bit 3 ignored
    b0 = n_ws; b1 = n_wclr;
    tx[0] = 8'h06; xact(8, 0);
    tx[0] = 8'h0E; xact(8, 1);
    tx[0] = 8'h04; xact(8, 0);
    chk("R2 wen_set count", n_ws - b0, 2);
    chk("R2 wen_clr count", n_wclr - b1, 1);

    // R12 invalid opcodes
    b0 = n_ws + n_wclr + n_pg;
    tx[0] = 8'h07; tx[1] = 8'h00; tx[2] = 8'h10; xact(24, 0);
    chk("R12 low bits 111 no oe", oe_seen, 0);
    tx[0] = 8'h16; xact(8, 0);
    tx[0] = 8'h00; xact(8, 1);
    chk("R12 no strobes", n_ws + n_wclr + n_pg - b0, 0);

    // R6/R7 page write with in-page wrap
    b0 = n_pg; b1 = n_wc;
    tx[0] = 8'h02; tx[1] = 8'h00; tx[2] = 8'h3E; tx[3] = 8'h11; tx[4] = 8'h22; tx[5] = 8'h33;
    xact(48, 0);
    chk("R6 page loads", n_pg - b0, 3);
    chk("R7 commit", n_wc - b1, 1);
    chk("R9 busy after commit", busy, 1);

    // R9 while busy: status only
    tx[0] = 8'h05; xact(16, 1);
    chk("R5 R9 busy status", rx[1], 8'hA5);
    tx[0] = 8'h03; tx[1] = 8'h00; tx[2] = 8'h3E; xact(40, 0);
    chk("R9 read ignored while busy", oe_seen, 0);
    b0 = n_ws;
    tx[0] = 8'h06; xact(8, 0);
    chk("R9 wren ignored while busy", n_ws - b0, 0);
    wait_idle();
    chk("R9 busy length", busy_len, WRC);

    tx[0] = 8'h03; tx[1] = 8'h00; tx[2] = 8'h3E; xact(40, 0);
    chk("R6 byte at 3E", rx[3], 8'h11);
    chk("R6 byte at 3F", rx[4], 8'h22);
    tx[0] = 8'h03; tx[1] = 8'h00; tx[2] = 8'h20; xact(32, 1);
    chk("R6 page wrap to 20", rx[3], 8'h33);

    // R7 mid-byte cs rise and no-data write
    b1 = n_wc;
    tx[0] = 8'h02; tx[1] = 8'h01; tx[2] = 8'h00; tx[3] = 8'h99; tx[4] = 8'hF0;
    xact(36, 0);
    chk("R7 mid-byte no busy", busy, 0);
    tx[0] = 8'h02; tx[1] = 8'h01; tx[2] = 8'h00; xact(24, 1);
    chk("R7 no commit", n_wc - b1, 0);
    tx[0] = 8'h03; tx[1] = 8'h01; tx[2] = 8'h00; xact(32, 0);
    chk("R7 array unchanged", rx[3], pat(12'h100));

    // R8 status write
    b0 = n_sc;
    tx[0] = 8'h01; tx[1] = 8'h8C; xact(16, 0);
    chk("R8 sr_commit", n_sc - b0, 1);
    chk("R8 sr_data", sr_data, 8'h8C);
    chk("R8 R9 busy", busy, 1);
    wait_idle();

    // R10 hold in the middle of a read data byte
    tx[0] = 8'h03; tx[1] = 8'h02; tx[2] = 8'h00; hold_bit = 27;
    xact(40, 1);
    hold_bit = -1;
    chk("R10 oe off in hold", hold_oe, 0);
    chk("R10 byte 0 resumes", rx[3], pat(12'h200));
    chk("R10 byte 1", rx[4], pat(12'h201));

    summary();
    $finish;
  end
endmodule